// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address for each beat of a synchronous DRAM burst. A command pulse (`start`) loads a start column, a burst-length code and an ordering choice. The first beat's address appears in the cycle after the pulse, and each later clock with `ce` high moves one beat further. On the final beat of a fixed-length burst the block raises `last_beat`. A full-page burst runs on, wrapping around the row, until a stop or a new command ends it.

A command controller drives `start` whenever it issues a read or write, and `stop` when it issues a burst terminate. The data path uses `col_out` and `valid` to index the beats. Pulling `ce` low suspends the sequence. While it is low, the outputs keep their values and commands are not taken.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is active, and after it is released with no command, `valid`, `last_beat` and `stop_illegal` are 0 and `col_out` is 0.
- R2: A `start` sampled with `ce` high sets `valid`, shows `start_col` as beat 0 on `col_out` in the next cycle, and captures `len_code` and `order_xor`. Changes to these inputs later in the burst have no effect.
- R3: `len_code` values are 000 for 1 beat, 001 for 2, 010 for 4, 011 for 8 and 111 for full page. The reserved values 100, 101 and 110 act as 1 beat. With `order_xor`=0 and a length of 2, 4 or 8, beat k is the start column plus k taken modulo the length in the low log2(length) bits. The bits above that window stay those of the start column.
- R4: With `order_xor`=1 and a length of 2, 4 or 8, beat k is the start column with its low log2(length) bits XORed with k. The higher bits are unchanged.
- R5: A full-page burst gives start column plus k modulo 256 and wraps from 255 to 0. It ignores `order_xor` and never raises `last_beat`.
- R6: For a fixed-length burst, `last_beat` is high exactly on beat length-1. After that beat `valid` falls, unless a new `start` arrives. While `valid` is low, `col_out` reads 0.
- R7: A `start` during a burst drops the rest of that burst and begins a fresh burst of the full new length at the new column. When `start` and `stop` arrive together, `start` wins.
- R8: A `stop` sampled with `ce` high during a full-page burst clears `valid` in the next cycle. During a fixed-length burst `stop` changes nothing in the sequence, and `stop_illegal` pulses high for one cycle.
- R9: While `ce` is low, `col_out`, `valid` and `last_beat` hold their values, `start` and `stop` are ignored, and `stop_illegal` is 0.
- R10: A `stop` with no burst running has no effect and raises no `stop_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; low suspends the sequence |
| start | input | 1 | Read/write command: load and begin a burst |
| start_col | input | COL_W (8) | Start column for the burst |
| len_code | input | 3 | Burst-length code (see R3) |
| order_xor | input | 1 | 0 sequential, 1 interleaved order |
| stop | input | 1 | Burst terminate request |
| col_out | output | COL_W (8) | Column address of the current beat |
| valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Current beat is the final one of a fixed-length burst |
| stop_illegal | output | 1 | One-cycle pulse: stop seen outside full-page mode |

## Verification
The bench goes after four failure modes. Bursts that start near the top of a window, such as 0xFD with length 8, catch a design that lets the carry leak into the upper bits: it would produce 0x100-range wrap errors instead of returning to 0xF8. Interleaved bursts from odd start columns catch an adder used in place of XOR, because the sequence would count up instead of flipping bits. A restart in the middle of a burst, a start coinciding with stop, and a stop inside a fixed-length burst each show up as a wrong beat count or a wrongly ending `valid` when priority is wrong. Suspend windows with commands pending expose a design that advances or accepts a command while `ce` is low.

// File: rtl/sdrcol_pkg.sv
package sdrcol_pkg;

  localparam int LEN_CODE_W = 3;
  localparam int SPAN_W     = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;

  // page: run until stop/restart; span_lg: log2 of the fixed burst length
  typedef struct packed {
    logic              page;
    order_e            order;
    logic [SPAN_W-1:0] span_lg;
  } burst_mode_t;

endpackage

// File: rtl/sdrcol_rst_sync.sv
module sdrcol_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/sdrcol_mode_dec.sv
module sdrcol_mode_dec
  import sdrcol_pkg::*;
(
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_xor,
  output burst_mode_t           mode
);

  always_comb begin
    mode.page    = 1'b0;
    mode.order   = order_xor ? ORDER_XOR : ORDER_SEQ;
    mode.span_lg = '0;
    case (len_code)
      LEN_1:    mode.span_lg = 3'd0;
      LEN_2:    mode.span_lg = 3'd1;
      LEN_4:    mode.span_lg = 3'd2;
      LEN_8:    mode.span_lg = 3'd3;
      LEN_PAGE: begin
        mode.page  = 1'b1;
        mode.order = ORDER_SEQ;
      end
      default:  mode.span_lg = 3'd0;
    endcase
  end

endmodule

// File: rtl/sdrcol_seq_ctrl.sv
module sdrcol_seq_ctrl
  import sdrcol_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  burst_mode_t      mode_in,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output burst_mode_t      mode,
  output logic             at_max,
  output logic             stop_err
);

  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q,   beat_d;
  logic [COL_W-1:0] base_q,   base_d;
  burst_mode_t      mode_q,   mode_d;
  logic             err_q,    err_d;
  logic [COL_W-1:0] beat_max;
  logic             final_beat;

  // highest beat index of a fixed-length burst
  always_comb begin
    for (int i = 0; i < COL_W; i++) begin
      beat_max[i] = (int'(mode_q.span_lg) > i);
    end
  end

  assign final_beat = !mode_q.page && (beat_q == beat_max);

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    base_d   = base_q;
    mode_d   = mode_q;
    err_d    = 1'b0;
    if (ce) begin
      if (start) begin
        active_d = 1'b1;
        beat_d   = '0;
        base_d   = start_col;
        mode_d   = mode_in;
      end else if (active_q) begin
        if (mode_q.page) begin
          if (stop) active_d = 1'b0;
          else      beat_d   = beat_q + 1'b1;
        end else begin
          if (stop) err_d = 1'b1;
          if (final_beat) active_d = 1'b0;
          else            beat_d   = beat_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mode_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
      base_q   <= base_d;
      mode_q   <= mode_d;
      err_q    <= err_d;
    end
  end

  assign active   = active_q;
  assign beat     = beat_q;
  assign base     = base_q;
  assign mode     = mode_q;
  assign at_max   = (beat_q == beat_max);
  assign stop_err = err_q;

endmodule

// File: rtl/sdrcol_addr_form.sv
module sdrcol_addr_form
  import sdrcol_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  burst_mode_t      mode,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] step_val;
  logic [COL_W-1:0] in_win;

  assign step_val = (mode.order == ORDER_XOR) ? (base ^ beat) : (base + beat);

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign in_win[i] = mode.page || (int'(mode.span_lg) > i);
    assign col[i]    = in_win[i] ? step_val[i] : base[i];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdrcol_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_xor,
  input  logic                  stop,
  output logic [COL_W-1:0]      col_out,
  output logic                  valid,
  output logic                  last_beat,
  output logic                  stop_illegal
);

  logic             rst_sync_n;
  burst_mode_t      mode_in;
  burst_mode_t      mode_cur;
  logic             act;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] col_raw;
  logic             at_max;
  logic             cur_page;

  sdrcol_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdrcol_mode_dec u_dec (
    .len_code  (len_code),
    .order_xor (order_xor),
    .mode      (mode_in)
  );

  sdrcol_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ce        (ce),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .mode_in   (mode_in),
    .active    (act),
    .beat      (beat),
    .base      (base),
    .mode      (mode_cur),
    .at_max    (at_max),
    .stop_err  (stop_illegal)
  );

  sdrcol_addr_form #(.COL_W(COL_W)) u_addr (
    .base (base),
    .beat (beat),
    .mode (mode_cur),
    .col  (col_raw)
  );

  assign cur_page  = mode_cur.page;
  assign valid     = act;
  assign col_out   = act ? col_raw : '0;
  assign last_beat = act && !cur_page && at_max;

endmodule

// File: rtl/sdrcol_checker.sv
module sdrcol_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic             page,
  input logic [COL_W-1:0] col_out,
  input logic             valid,
  input logic             last_beat,
  input logic             stop_illegal
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && start) |=> (valid && col_out == $past(start_col)));

  assert_full_no_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && page) |-> !last_beat);

  assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && last_beat && ce && !start) |=> !valid);

  assert_stop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && page && ce && stop && !start) |=> (!valid && !stop_illegal));

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_illegal |-> ($past(valid) && $past(stop) && $past(ce) && !$past(start)));

  assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(col_out) && $stable(valid) && $stable(last_beat) && !stop_illegal));

  assert_idle_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && ce && !start) |=> (!valid && !stop_illegal));

endmodule

bind sdram_burst_colgen sdrcol_checker #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ce           (ce),
  .start        (start),
  .stop         (stop),
  .start_col    (start_col),
  .page         (cur_page),
  .col_out      (col_out),
  .valid        (valid),
  .last_beat    (last_beat),
  .stop_illegal (stop_illegal)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       ce;
  logic       start;
  logic [7:0] start_col;
  logic [2:0] len_code;
  logic       order_xor;
  logic       stop;
  logic [7:0] col_out;
  logic       valid;
  logic       last_beat;
  logic       stop_illegal;

  int checks = 0;
  int errors = 0;
  bit run    = 0;
  bit done   = 0;

  // reference model state
  int m_act  = 0;
  int m_k    = 0;
  int m_base = 0;
  int m_len  = 1;  // 0 means full page
  int m_il   = 0;
  int m_ill  = 0;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .start_col(start_col),
    .len_code(len_code), .order_xor(order_xor), .stop(stop),
    .col_out(col_out), .valid(valid), .last_beat(last_beat), .stop_illegal(stop_illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int w;
    if (m_act == 0) return 0;
    if (m_len == 0) return (m_base + m_k) % 256;
    w = (m_base / m_len) * m_len;
    if (m_il != 0) return w + ((m_base % m_len) ^ m_k);
    return w + ((m_base % m_len + m_k) % m_len);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_k = 0; m_ill = 0;
    end else begin
      m_ill = 0;
      if (ce) begin
        if (start) begin
          m_act = 1; m_k = 0; m_base = int'(start_col);
          m_len = len_of(len_code); m_il = int'(order_xor);
        end else if (m_act != 0) begin
          if (m_len == 0) begin
            if (stop) m_act = 0;
            else      m_k = (m_k + 1) % 256;
          end else begin
            if (stop) m_ill = 1;
            if (m_k == m_len - 1) m_act = 0;
            else                  m_k = m_k + 1;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run) begin
      string ctag;
      ctag = (m_len == 0) ? "R5 col" : ((m_il != 0) ? "R4 col" : "R3 col");
      check(ctag, int'(col_out), exp_col());
      check("R6 valid", int'(valid), m_act);
      check("R6 last_beat", int'(last_beat),
            ((m_act != 0) && (m_len != 0) && (m_k == m_len - 1)) ? 1 : 0);
      check("R8 stop_illegal", int'(stop_illegal), m_ill);
    end
  end

  task automatic drive(input logic st, input logic [7:0] c, input logic [2:0] code,
                       input logic typ, input logic sp, input logic e);
    @(negedge clk);
    #1;
    start = st; start_col = c; len_code = code; order_xor = typ; stop = sp; ce = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1; start = 1'b0; start_col = '0;
    len_code = '0; order_xor = 1'b0; stop = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", int'(valid), 0);
    check("R1 col in reset", int'(col_out), 0);
    rst_n = 1'b1;
    idle(4);
    check("R1 valid after release", int'(valid), 0);
    check("R1 stop_illegal after release", int'(stop_illegal), 0);
    check("R1 last after release", int'(last_beat), 0);
    run = 1;

    // R2 / R3: sequential 4 from 0x16, mode inputs changed mid-burst
    drive(1'b1, 8'h16, 3'b010, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 8'h00, 3'b111, 1'b1, 1'b0, 1'b1);
    check("R2 first beat", int'(col_out), 'h16);
    idle(5);
    // R3: sequential 8 near top of column space
    drive(1'b1, 8'hFD, 3'b011, 1'b0, 1'b0, 1'b1);
    idle(9);
    // R3: sequential 2
    drive(1'b1, 8'h9B, 3'b001, 1'b0, 1'b0, 1'b1);
    idle(3);
    // R4: interleaved 8, 4, 2
    drive(1'b1, 8'h35, 3'b011, 1'b1, 1'b0, 1'b1);
    idle(9);
    drive(1'b1, 8'h0A, 3'b010, 1'b1, 1'b0, 1'b1);
    idle(5);
    drive(1'b1, 8'h01, 3'b001, 1'b1, 1'b0, 1'b1);
    idle(3);
    // R6: single beat and reserved code
    drive(1'b1, 8'h77, 3'b000, 1'b0, 1'b0, 1'b1);
    idle(2);
    drive(1'b1, 8'h78, 3'b101, 1'b1, 1'b0, 1'b1);
    idle(2);
    // R7: restart mid-burst
    drive(1'b1, 8'h20, 3'b011, 1'b0, 1'b0, 1'b1);
    idle(2);
    drive(1'b1, 8'h53, 3'b011, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
    check("R7 restart beat", int'(col_out), 'h53);
    idle(9);
    // R5: full page across the wrap, interleave bit ignored
    drive(1'b1, 8'hFC, 3'b111, 1'b1, 1'b0, 1'b1);
    idle(10);
    // R7: start and stop together, start wins
    drive(1'b1, 8'h40, 3'b111, 1'b0, 1'b1, 1'b1);
    idle(3);
    // R8: stop ends full page
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1);
    idle(2);
    // R8: stop in fixed length ignored and flagged
    drive(1'b1, 8'h60, 3'b011, 1'b0, 1'b0, 1'b1);
    idle(2);
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1);
    idle(8);
    // R9: suspend with commands pending
    drive(1'b1, 8'h40, 3'b010, 1'b0, 1'b0, 1'b1);
    idle(1);
    drive(1'b1, 8'h99, 3'b011, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 8'h99, 3'b011, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 8'h99, 3'b011, 1'b0, 1'b1, 1'b0);
    check("R9 held col", int'(col_out), 'h41);
    idle(5);
    // R10: stop while idle
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1);
    idle(1);
    check("R10 no flag when idle", int'(stop_illegal), 0);
    check("R10 stays idle", int'(valid), 0);

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [2:0] codes [6];
      codes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111, 3'b110};
      drive(($urandom_range(0, 7) == 0), 8'($urandom_range(0, 255)),
            codes[$urandom_range(0, 5)], 1'($urandom_range(0, 1)),
            ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) != 0));
    end
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule